// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the repeated start condition for an I2C bus master. Software sets a request bit; the block pulls SCL low, lets SDA go high, releases SCL, holds both lines high for one time quantum and then pulls SDA low while SCL stays high. A time quantum is one run of a down-counter that is loaded from a 7-bit reload value. Both bus lines are driven as open-drain enables (1 means pull low) and are read back through a synchronizer. Each step waits for the line it has just changed to reach its new level, so a slave that holds SCL low lengthens the sequence.

While the sequence runs, the block guards its register-style interface. A write to the transmit buffer is refused and raises a write-collision flag. Writes to the other bus-event control bits are dropped. The block watches the lines for arbitration loss. If it sees a loss, it drops both lines, ends the sequence and raises a sticky bus-collision flag. A status bit follows Start and Stop conditions seen on the lines. An interrupt flag marks the end of the final time quantum.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A request pulse on `rsen_set` is accepted only when the block is idle and `bus_busy` is low. In any other case it has no effect: `rsen` stays 0 and `scl_oe` stays 0.
- R2: On the clock edge that accepts a request, `rsen` becomes 1 and `scl_oe` becomes 1. `sda_oe` is 0 at the moment SCL is released, and SCL is released only after one quantum has passed with SCL seen low and SDA seen high.
- R3: Both lines pass through a two-flop synchronizer. The edge that sets `sda_oe` to 1 comes exactly N+2 rising edges after the first rising edge at which the SCL line is high. Here N is the reload value with 0 counted as 1. A slave that holds SCL low therefore delays this edge, and `sda_oe` stays 0 for as long as SCL is held.
- R4: Exactly N clocks after `sda_oe` rises, `sif` becomes 1 and `rsen` becomes 0 on the same edge. After that, `sda_oe` stays 1.
- R5: `start_seen` becomes 1 within four clocks after SDA falls while SCL is high. It becomes 0 after SDA rises while SCL is high.
- R6: A reload value of 0 gives a quantum of one clock.
- R7: A `txb_wr` while the sequence runs sets `wcol` and leaves `txb_q` unchanged. This includes a write on the edge that completes the sequence. In idle, a write loads `txb_q`.
- R8: A `ctl_wr` while the sequence runs leaves `ctl_q` unchanged. In idle, it loads `ctl_q`.
- R9: If SDA is seen low at the moment SCL is seen to rise, `bcol` is set. On the same edge `scl_oe`, `sda_oe` and `rsen` go to 0 and the block returns to idle.
- R10: If SCL is seen low while both lines should be high (before SDA is pulled low), the same collision response as R9 follows.
- R11: `sif`, `wcol` and `bcol` stay set until their clear input is pulsed. When a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brg_reload | input | 7 | Quantum length in clocks (0 counts as 1) |
| rsen_set | input | 1 | Request pulse for a repeated start |
| bus_busy | input | 1 | Another bus event of the master is in progress |
| txb_wr | input | 1 | Transmit-buffer write strobe |
| txb_wdata | input | 8 | Transmit-buffer write data |
| ctl_wr | input | 1 | Write strobe for the other event-request bits |
| ctl_wdata | input | 4 | Data for the other event-request bits |
| sif_clr | input | 1 | Clear the interrupt flag |
| wcol_clr | input | 1 | Clear the write-collision flag |
| bcol_clr | input | 1 | Clear the bus-collision flag |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rsen | output | 1 | Request bit; clears itself when done |
| txb_q | output | 8 | Transmit buffer contents |
| ctl_q | output | 4 | Other event-request bits |
| start_seen | output | 1 | Start condition seen (cleared by Stop) |
| sif | output | 1 | Interrupt flag |
| wcol | output | 1 | Write-collision flag |
| bcol | output | 1 | Bus-collision flag |

## Verification
The critical coincidence is the last edge of the final quantum. On that one edge the sequence completes and may also meet a transmit-buffer write and software clears of the interrupt and write-collision flags. The bench counts clocks from the edge where `sda_oe` rises. It then lands the write together with both clears exactly on the completion edge. The expected result is the interrupt flag set, the write still treated as a collision with the buffer unchanged, and `rsen` cleared. A second pair of concurrent functions is a slave holding SCL low at the same time as it pulls SDA low. The release of SCL then has to be judged as a collision rather than as a stretch.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_SCL_LO,
    RS_SDA_HI,
    RS_SCL_REL,
    RS_BOTH_HI,
    RS_SDA_LO
  } rs_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;              // idle bus level is high
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic [W-1:0] eff;

  assign eff = (load_val == '0) ? ONE : load_val;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= eff;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  // quantum over when the count reaches its final cycle (or has stopped)
  assign done = (cnt <= ONE);
endmodule

// File: rtl/i2c_bus_cond_watch.sv
module i2c_bus_cond_watch (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev
);
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) sda_d <= 1'b1;
    else     sda_d <= sda_s;
  end

  assign start_ev = scl_s &  sda_d & ~sda_s;
  assign stop_ev  = scl_s & ~sda_d &  sda_s;
endmodule

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq
  import i2c_rs_pkg::*;
#(
  parameter int BRG_W       = 7,
  parameter int TXB_W       = 8,
  parameter int CTL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             rsen_set,
  input  logic             bus_busy,
  input  logic             txb_wr,
  input  logic [TXB_W-1:0] txb_wdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sif_clr,
  input  logic             wcol_clr,
  input  logic             bcol_clr,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             rsen,
  output logic [TXB_W-1:0] txb_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             start_seen,
  output logic             sif,
  output logic             wcol,
  output logic             bcol
);
  rs_state_t state, state_n;
  logic scl_s, sda_s;
  logic tmr_load, tmr_done;
  logic start_ev, stop_ev;
  logic scl_n, sda_n, rsen_n;
  logic sif_set, bcol_set;
  logic active;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  i2c_baud_timer #(.W(BRG_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(brg_reload),
    .done(tmr_done));

  i2c_bus_cond_watch u_watch (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev));

  assign active = (state != RS_IDLE);

  always_comb begin
    state_n  = state;
    scl_n    = scl_oe;
    sda_n    = sda_oe;
    rsen_n   = rsen;
    tmr_load = 1'b0;
    sif_set  = 1'b0;
    bcol_set = 1'b0;
    case (state)
      RS_IDLE: begin
        if (rsen_set && !bus_busy) begin
          state_n = RS_SCL_LO;
          scl_n   = 1'b1;
          rsen_n  = 1'b1;
        end
      end
      RS_SCL_LO: begin
        if (!scl_s) begin
          tmr_load = 1'b1;
          sda_n    = 1'b0;
          state_n  = RS_SDA_HI;
        end
      end
      RS_SDA_HI: begin
        if (tmr_done && sda_s) begin
          scl_n   = 1'b0;
          state_n = RS_SCL_REL;
        end
      end
      RS_SCL_REL: begin
        if (scl_s) begin
          if (!sda_s) begin
            bcol_set = 1'b1;
          end else begin
            tmr_load = 1'b1;
            state_n  = RS_BOTH_HI;
          end
        end
      end
      RS_BOTH_HI: begin
        if (!scl_s) begin
          bcol_set = 1'b1;
        end else if (tmr_done) begin
          sda_n    = 1'b1;
          tmr_load = 1'b1;
          state_n  = RS_SDA_LO;
        end
      end
      RS_SDA_LO: begin
        if (tmr_done) begin
          state_n = RS_IDLE;
          rsen_n  = 1'b0;
          sif_set = 1'b1;
        end
      end
      default: state_n = RS_IDLE;
    endcase
    if (bcol_set) begin
      state_n = RS_IDLE;
      scl_n   = 1'b0;
      sda_n   = 1'b0;
      rsen_n  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RS_IDLE;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
      rsen       <= 1'b0;
      txb_q      <= '0;
      ctl_q      <= '0;
      start_seen <= 1'b0;
      sif        <= 1'b0;
      wcol       <= 1'b0;
      bcol       <= 1'b0;
    end else begin
      state  <= state_n;
      scl_oe <= scl_n;
      sda_oe <= sda_n;
      rsen   <= rsen_n;
      if (txb_wr && !active) txb_q <= txb_wdata;
      if (ctl_wr && !active) ctl_q <= ctl_wdata;
      if (start_ev)     start_seen <= 1'b1;
      else if (stop_ev) start_seen <= 1'b0;
      sif  <= sif_set  | (sif  & ~sif_clr);
      wcol <= (txb_wr & active) | (wcol & ~wcol_clr);
      bcol <= bcol_set | (bcol & ~bcol_clr);
    end
  end
endmodule

// File: rtl/i2c_rstart_seq_chk.sv
module i2c_rstart_seq_chk #(
  parameter int TXB_W = 8,
  parameter int CTL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rsen_set,
  input logic             bus_busy,
  input logic             rsen,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             sif,
  input logic             bcol,
  input logic             bcol_clr,
  input logic [TXB_W-1:0] txb_q,
  input logic [CTL_W-1:0] ctl_q
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(rsen) |-> $past(rsen_set && !bus_busy));

  assert_scl_release_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(scl_oe) && rsen) |-> !sda_oe);

  assert_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sif) |-> (!rsen && sda_oe));

  assert_txb_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rsen) |-> $stable(txb_q));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rsen) |-> $stable(ctl_q));

  assert_bcol_release_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bcol) |-> (!scl_oe && !sda_oe && !rsen));

  assert_bcol_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(bcol) && !$past(bcol_clr)) |-> bcol);
endmodule

bind i2c_rstart_seq i2c_rstart_seq_chk #(.TXB_W(TXB_W), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst(rst), .rsen_set(rsen_set), .bus_busy(bus_busy),
  .rsen(rsen), .scl_oe(scl_oe), .sda_oe(sda_oe), .sif(sif), .bcol(bcol),
  .bcol_clr(bcol_clr), .txb_q(txb_q), .ctl_q(ctl_q));

// File: tb/i2c_rstart_seq_bench.sv
`timescale 1ns/1ps
module i2c_rstart_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] brg_reload = 7'd4;
  logic       rsen_set = 0, bus_busy = 0, txb_wr = 0, ctl_wr = 0;
  logic [7:0] txb_wdata = 0;
  logic [3:0] ctl_wdata = 0;
  logic       sif_clr = 0, wcol_clr = 0, bcol_clr = 0;
  logic       slv_scl_low = 0, slv_sda_low = 0;
  logic       scl_oe, sda_oe, rsen, start_seen, sif, wcol, bcol;
  logic [7:0] txb_q;
  logic [3:0] ctl_q;
  logic       scl_line, sda_line;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign scl_line = ~(scl_oe | slv_scl_low);
  assign sda_line = ~(sda_oe | slv_sda_low);

  i2c_rstart_seq u_i2c_rstart_seq (
    .clk(clk), .rst(rst), .brg_reload(brg_reload), .rsen_set(rsen_set),
    .bus_busy(bus_busy), .txb_wr(txb_wr), .txb_wdata(txb_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sif_clr(sif_clr),
    .wcol_clr(wcol_clr), .bcol_clr(bcol_clr), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .rsen(rsen),
    .txb_q(txb_q), .ctl_q(ctl_q), .start_seen(start_seen), .sif(sif),
    .wcol(wcol), .bcol(bcol));

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic go(input int rl);
    brg_reload = 7'(rl);
    rsen_set = 1'b1;
    @(negedge clk);
    rsen_set = 1'b0;
    chk("R2", "rsen after accept", int'(rsen), 1);
    chk("R2", "scl_oe after accept", int'(scl_oe), 1);
  endtask

  task automatic wait_release();
    while (!(rsen && !scl_oe)) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "reset scl_oe", int'(scl_oe), 0);
    chk("R2", "reset sda_oe", int'(sda_oe), 0);
    chk("R4", "reset rsen", int'(rsen), 0);
    chk("R11", "reset flags", int'({sif, wcol, bcol}), 0);
  endtask

  task automatic t_busy();
    bus_busy = 1'b1;
    rsen_set = 1'b1;
    @(negedge clk);
    rsen_set = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rsen while busy", int'(rsen), 0);
    chk("R1", "scl_oe while busy", int'(scl_oe), 0);
    bus_busy = 1'b0;
  endtask

  task automatic t_normal(input int rl, input int n, input string rq);
    int j;
    go(rl);
    wait_release();
    chk("R2", "sda_oe at scl release", int'(sda_oe), 0);
    j = 0;
    while (!sda_oe) begin @(negedge clk); j++; end
    chk("R3", "high window", j, n + 3);   // N+2 edges after first edge seeing SCL high
    j = 0;
    while (!sif) begin @(negedge clk); j++; end
    chk(rq, "sda low quantum", j, n);
    chk("R4", "rsen self clear", int'(rsen), 0);
    chk("R4", "sda held low", int'(sda_oe), 1);
    repeat (4) @(negedge clk);
    chk("R5", "start seen", int'(start_seen), 1);
    chk("R11", "sif sticky", int'(sif), 1);
    sif_clr = 1'b1; @(negedge clk); sif_clr = 1'b0;
    chk("R11", "sif cleared", int'(sif), 0);
  endtask

  task automatic t_writes();
    txb_wr = 1'b1; txb_wdata = 8'h3C; ctl_wr = 1'b1; ctl_wdata = 4'h5;
    @(negedge clk);
    txb_wr = 1'b0; ctl_wr = 1'b0;
    chk("R7", "idle txb write", int'(txb_q), 8'h3C);
    chk("R8", "idle ctl write", int'(ctl_q), 4'h5);
    go(6);
    txb_wr = 1'b1; txb_wdata = 8'hA5; ctl_wr = 1'b1; ctl_wdata = 4'hF;
    rsen_set = 1'b1;
    @(negedge clk);
    txb_wr = 1'b0; ctl_wr = 1'b0; rsen_set = 1'b0;
    while (!sif) @(negedge clk);
    chk("R7", "txb unchanged", int'(txb_q), 8'h3C);
    chk("R7", "wcol set", int'(wcol), 1);
    chk("R8", "ctl unchanged", int'(ctl_q), 4'h5);
    wcol_clr = 1'b1; sif_clr = 1'b1; @(negedge clk);
    wcol_clr = 1'b0; sif_clr = 1'b0;
    chk("R11", "wcol cleared", int'(wcol), 0);
  endtask

  task automatic t_bcol_sda();
    go(4);
    while (!(rsen && scl_oe && !sda_oe)) @(negedge clk);
    slv_scl_low = 1'b1;
    wait_release();
    slv_sda_low = 1'b1;
    repeat (3) @(negedge clk);
    slv_scl_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "bcol on sda low", int'(bcol), 1);
    chk("R9", "lines released", int'({scl_oe, sda_oe}), 0);
    chk("R9", "rsen cleared", int'(rsen), 0);
    slv_sda_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5", "stop clears start_seen", int'(start_seen), 0);
    chk("R11", "bcol sticky", int'(bcol), 1);
    bcol_clr = 1'b1; @(negedge clk); bcol_clr = 1'b0;
    chk("R11", "bcol cleared", int'(bcol), 0);
  endtask

  task automatic t_stretch();
    int j;
    go(4);
    while (!(rsen && scl_oe && !sda_oe)) @(negedge clk);
    slv_scl_low = 1'b1;
    wait_release();
    j = 0;
    repeat (10) begin @(negedge clk); j += int'(sda_oe); end
    chk("R3", "sda_oe during stretch", j, 0);
    slv_scl_low = 1'b0;
    j = 0;
    while (!sda_oe) begin @(negedge clk); j++; end
    chk("R3", "high window after stretch", j, 4 + 3);
    while (!sif) @(negedge clk);
    sif_clr = 1'b1; @(negedge clk); sif_clr = 1'b0;
  endtask

  task automatic t_bcol_scl();
    go(8);
    wait_release();
    repeat (4) @(negedge clk);
    slv_scl_low = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10", "bcol on scl low", int'(bcol), 1);
    chk("R10", "lines released", int'({scl_oe, sda_oe}), 0);
    chk("R10", "rsen cleared", int'(rsen), 0);
    slv_scl_low = 1'b0;
    bcol_clr = 1'b1; @(negedge clk); bcol_clr = 1'b0;
  endtask

  task automatic t_same_edge();
    go(3);
    wait_release();
    while (!sda_oe) @(negedge clk);
    repeat (2) @(negedge clk);          // next posedge completes the sequence
    txb_wr = 1'b1; txb_wdata = 8'h99; sif_clr = 1'b1; wcol_clr = 1'b1;
    @(negedge clk);
    txb_wr = 1'b0; sif_clr = 1'b0; wcol_clr = 1'b0;
    chk("R11", "sif set beats clear", int'(sif), 1);
    chk("R7", "wcol on completion edge", int'(wcol), 1);
    chk("R7", "txb kept on completion edge", int'(txb_q), 8'h3C);
    chk("R4", "rsen cleared at completion", int'(rsen), 0);
    txb_wr = 1'b1; @(negedge clk); txb_wr = 1'b0;
    chk("R7", "txb write after completion", int'(txb_q), 8'h99);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_busy();
    t_normal(4, 4, "R4");
    t_writes();
    t_bcol_sda();
    t_normal(0, 1, "R6");
    t_stretch();
    t_bcol_scl();
    t_same_edge();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule